// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream. It keeps a chain of stages that all run on one system clock. The word is captured through an active-low load input. It is then moved one stage at a time toward the last stage, and the last stage drives a true serial output and an inverted serial output. A serial input feeds the first stage. If one instance's true output is wired to the serial input of another, the two form a single longer converter.

Shifting is set by a combined shift clock, which is the logical OR of two inputs: a shift clock and an active-low clock enable. Both are sampled on the system clock like any other input. A stage move happens only in a system cycle where the combined value goes from low to high. The two inputs play the same role, so either one can act as the clock and the other as the enable. While the load input is low, the stages follow the parallel inputs on every system cycle, and load takes priority over any shift.

Top module: `piso_chain_reg`

## Requirements
- R1: While sysRst is high at a system clock edge, every stage becomes 0, so serOut reads 0 and serOutN reads 1. The remembered combined-clock value is set high, so the first cycle after reset cannot shift.
- R2: At any system edge where loadN is low, every stage i takes parIn[i], whatever shiftClk and clkEnN are doing. This repeats each cycle for as long as loadN stays low.
- R3: When loadN is high and the combined clock (shiftClk OR clkEnN) is sampled high after being sampled low the cycle before, stage i+1 takes the old stage i. A combined clock that stays high causes no further moves. With parIn[WIDTH-1] loaded into the last stage, the word therefore leaves MSB first.
- R4: On each such shift, stage 0 takes the value on serIn.
- R5: shiftClk and clkEnN are interchangeable: pulsing either input low and then high while the other is held low gives one shift per pulse.
- R6: While clkEnN is held high, toggling shiftClk causes no shift and leaves the stages unchanged.
- R7: If clkEnN rises while shiftClk is low, and the combined clock was low in the previous cycle, the stages shift exactly once.
- R8: If loadN goes from low to high while shiftClk or clkEnN is already high, no shift happens on release or afterwards until the combined clock next goes low and then high.
- R9: serOut always equals the last stage (WIDTH-1), and serOutN always equals its inverse.
- R10: When two instances are cascaded (the second's serOut drives the first's serIn) and loaded with words A and B, the first instance's serOut, sampled before each of 16 combined-clock rising edges, gives A MSB first followed by B MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock; all state changes on its rising edge |
| sysRst | input | 1 | Synchronous active-high reset |
| shiftClk | input | 1 | Shift clock, ORed with clkEnN to form the combined clock |
| clkEnN | input | 1 | Active-low clock enable; interchangeable with shiftClk |
| loadN | input | 1 | Active-low level-sensitive parallel load, highest priority |
| parIn | input | WIDTH | Parallel word; bit i loads stage i |
| serIn | input | 1 | Serial data entering stage 0 on a shift |
| serOut | output | 1 | Last stage value |
| serOutN | output | 1 | Inverse of the last stage value |

## Verification
The bench builds two instances with the default WIDTH of 8 and chains them head to tail. This lets a single 16-edge run check the MSB-first order across the boundary between instances, including the handoff from the tail's last stage into the head's first stage. With an 8-stage width, every bit of a loaded word can be seen at the outputs within a short run. That keeps the directed checks on enable gating, enable-edge shifts and load release cheap, and lets a randomized phase compare the outputs every cycle against a bench model.

// File: rtl/piso_chain_pkg.sv
package piso_chain_pkg;

  // Strobes passed from control to datapath each system cycle
  typedef struct packed {
    logic loadStb;   // copy parallel word into all stages
    logic shiftStb;  // move every stage one place toward the last
  } chainCtl_t;

endpackage

// File: rtl/piso_chain_ctl.sv
module piso_chain_ctl
  import piso_chain_pkg::*;
(
  input  logic      sysClk,
  input  logic      sysRst,
  input  logic      shiftClk,
  input  logic      clkEnN,
  input  logic      loadN,
  output chainCtl_t ctlStb
);

  logic combClk;
  logic combPrev;

  // Gated-OR: either input may serve as clock, the other as enable
  assign combClk = shiftClk | clkEnN;

  // Previous combined value; reset high so no edge is seen right after reset
  always_ff @(posedge sysClk) begin
    if (sysRst) begin
      combPrev <= 1'b1;
    end else begin
      combPrev <= combClk;
    end
  end

  always_comb begin
    ctlStb          = '0;
    ctlStb.loadStb  = ~loadN;
    ctlStb.shiftStb = loadN & combClk & ~combPrev;
  end

endmodule

// File: rtl/piso_chain_dp.sv
module piso_chain_dp
  import piso_chain_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             sysClk,
  input  logic             sysRst,
  input  chainCtl_t        ctlStb,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic [WIDTH-1:0] stageQ
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] shiftIn;
  logic [WIDTH-1:0] stageNext;

  // Source of each stage on a shift: serial input for stage 0, neighbour otherwise
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign shiftIn[gi] = serIn;
      end else begin : g_body
        assign shiftIn[gi] = stageQ[gi-1];
      end

      always_comb begin
        if (ctlStb.loadStb) begin
          stageNext[gi] = parIn[gi];
        end else if (ctlStb.shiftStb) begin
          stageNext[gi] = shiftIn[gi];
        end else begin
          stageNext[gi] = stageQ[gi];
        end
      end
    end
  endgenerate

  always_ff @(posedge sysClk) begin
    if (sysRst) begin
      stageQ <= '0;
    end else begin
      stageQ <= stageNext;
    end
  end

  // LAST kept as the named tap for the serial outputs at the top
  logic unusedLast;
  assign unusedLast = stageQ[LAST];

endmodule

// File: rtl/piso_chain_reg.sv
module piso_chain_reg
  import piso_chain_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             sysClk,
  input  logic             sysRst,
  input  logic             shiftClk,
  input  logic             clkEnN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic             serOut,
  output logic             serOutN
);

  localparam int LAST = WIDTH - 1;

  chainCtl_t        ctlStb;
  logic [WIDTH-1:0] stageQ;

  piso_chain_ctl ctl_i (
    .sysClk   (sysClk),
    .sysRst   (sysRst),
    .shiftClk (shiftClk),
    .clkEnN   (clkEnN),
    .loadN    (loadN),
    .ctlStb   (ctlStb)
  );

  piso_chain_dp #(.WIDTH(WIDTH)) dp_i (
    .sysClk (sysClk),
    .sysRst (sysRst),
    .ctlStb (ctlStb),
    .parIn  (parIn),
    .serIn  (serIn),
    .stageQ (stageQ)
  );

  assign serOut  = stageQ[LAST];
  assign serOutN = ~stageQ[LAST];

endmodule

// File: rtl/piso_chain_chk.sv
module piso_chain_chk #(
  parameter int WIDTH = 8
) (
  input logic             sysClk,
  input logic             sysRst,
  input logic             shiftClk,
  input logic             clkEnN,
  input logic             loadN,
  input logic [WIDTH-1:0] parIn,
  input logic             serIn,
  input logic             serOut,
  input logic             serOutN,
  input logic [WIDTH-1:0] stageQ
);

  localparam int LAST = WIDTH - 1;

  // Checker's own record of the sampled combined clock
  logic chkPrev;
  always_ff @(posedge sysClk) begin
    if (sysRst) chkPrev <= 1'b1;
    else        chkPrev <= shiftClk | clkEnN;
  end

  logic edgeSeen;
  assign edgeSeen = loadN & ~chkPrev & (shiftClk | clkEnN);

  a_r1_reset_clears: assert property (@(posedge sysClk)
    sysRst |=> (stageQ == '0));

  a_r2_load_copies: assert property (@(posedge sysClk) disable iff (sysRst)
    !loadN |=> (stageQ == $past(parIn)));

  a_r3_shift_moves: assert property (@(posedge sysClk) disable iff (sysRst)
    edgeSeen |=> (stageQ[LAST:1] == $past(stageQ[LAST-1:0])));

  a_r4_serial_enters: assert property (@(posedge sysClk) disable iff (sysRst)
    edgeSeen |=> (stageQ[0] == $past(serIn)));

  a_r6_enable_blocks: assert property (@(posedge sysClk) disable iff (sysRst)
    (loadN && clkEnN && chkPrev) |=> $stable(stageQ));

  a_r7_enable_edge: assert property (@(posedge sysClk) disable iff (sysRst)
    (loadN && !chkPrev && clkEnN && !shiftClk) |=> (stageQ[LAST:1] == $past(stageQ[LAST-1:0])));

  a_r8_no_edge_hold: assert property (@(posedge sysClk) disable iff (sysRst)
    (loadN && !edgeSeen) |=> $stable(stageQ));

  a_r9_outputs: assert property (@(posedge sysClk) disable iff (sysRst)
    (serOut == stageQ[LAST]) && (serOutN == ~serOut));

endmodule

bind piso_chain_reg piso_chain_chk #(.WIDTH(WIDTH)) chk_i (
  .sysClk   (sysClk),
  .sysRst   (sysRst),
  .shiftClk (shiftClk),
  .clkEnN   (clkEnN),
  .loadN    (loadN),
  .parIn    (parIn),
  .serIn    (serIn),
  .serOut   (serOut),
  .serOutN  (serOutN),
  .stageQ   (stageQ)
);

// File: tb/piso_chain_reg_tb.sv
module piso_chain_reg_tb_top;

  localparam int W = 8;

  logic         sysClk = 1'b0;
  logic         sysRst = 1'b1;
  logic         shiftClk = 1'b1;
  logic         clkEnN = 1'b0;
  logic         loadN = 1'b1;
  logic [W-1:0] parHead = '0;
  logic [W-1:0] parTail = '0;
  logic         tbSerIn = 1'b0;
  logic         headOut, headOutN, tailOut, tailOutN;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Bench model of both stage chains
  logic [W-1:0] mHead, mTail;
  logic         mPrev;

  always #10 sysClk = ~sysClk;

  piso_chain_reg #(.WIDTH(W)) dut_i (
    .sysClk(sysClk), .sysRst(sysRst), .shiftClk(shiftClk), .clkEnN(clkEnN),
    .loadN(loadN), .parIn(parHead), .serIn(tailOut),
    .serOut(headOut), .serOutN(headOutN)
  );

  piso_chain_reg #(.WIDTH(W)) tail_i (
    .sysClk(sysClk), .sysRst(sysRst), .shiftClk(shiftClk), .clkEnN(clkEnN),
    .loadN(loadN), .parIn(parTail), .serIn(tbSerIn),
    .serOut(tailOut), .serOutN(tailOutN)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one system cycle, then update the model from the requirements
  task automatic step(input logic rst, input logic ld, input logic c, input logic e,
                      input logic [W-1:0] pH, input logic [W-1:0] pT, input logic s);
    logic comb;
    logic oldTailLast;
    @(negedge sysClk);
    sysRst = rst; loadN = ld; shiftClk = c; clkEnN = e;
    parHead = pH; parTail = pT; tbSerIn = s;
    @(posedge sysClk);
    #1;
    comb = c | e;
    oldTailLast = mTail[W-1];
    if (rst) begin
      mHead = '0; mTail = '0; mPrev = 1'b1;
    end else begin
      if (!ld) begin
        mHead = pH; mTail = pT;
      end else if (!mPrev && comb) begin
        mHead = {mHead[W-2:0], oldTailLast};
        mTail = {mTail[W-2:0], s};
      end
      mPrev = comb;
    end
  endtask

  task automatic hold(input logic c, input logic e);
    step(1'b0, 1'b1, c, e, parHead, parTail, tbSerIn);
  endtask

  task automatic chkModel(input string req);
    chk(req, {13'd0, headOut, headOutN, tailOut}, {13'd0, mHead[W-1], ~mHead[W-1], mTail[W-1]});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge sysClk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] stream;
    logic [W-1:0] wa, wb;
    void'($urandom(32'd4711));

    // R1: reset with combined clock high
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R1 serOut after reset", {15'd0, headOut}, 16'd0);
    chk("R1 R9 serOutN after reset", {15'd0, headOutN}, 16'd1);
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1);
    chk("R1 no shift on first cycle", {15'd0, headOut}, 16'd0);

    // R2 + R10: load two words with clock high, then release (R8)
    wa = 8'hB4; wb = 8'h6D;
    step(1'b0, 1'b0, 1'b1, 1'b0, wa, wb, 1'b0);
    chk("R2 load last stage", {15'd0, headOut}, {15'd0, wa[7]});
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R8 release with clock high", {15'd0, headOut}, {15'd0, wa[7]});
    hold(1'b1, 1'b0);
    chk("R3 level high gives no extra shift", {15'd0, headOut}, {15'd0, wa[7]});
    stream = '0;
    for (int k = 0; k < 16; k++) begin
      stream = {stream[14:0], headOut};
      chk("R9 inverse output", {15'd0, headOutN}, {15'd0, ~headOut});
      hold(1'b0, 1'b0);
      hold(1'b1, 1'b0);
    end
    chk("R10 R3 R4 cascade stream", stream, {wa, wb});

    // R6: enable high blocks clock toggles
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'h00, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    hold(1'b1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      hold(1'b0, 1'b1);
      hold(1'b1, 1'b1);
    end
    chk("R6 enable high blocks shift", {15'd0, headOut}, 16'd1);
    hold(1'b1, 1'b0);
    chk("R6 enable fall with clock high", {15'd0, headOut}, 16'd1);

    // R7: enable rises while clock low
    hold(1'b0, 1'b0);
    hold(1'b0, 1'b1);
    chk("R7 enable edge shifts once", {15'd0, headOut}, 16'd0);
    chk("R7 model agreement", {15'd0, headOut}, {15'd0, mHead[W-1]});

    // R5: clkEnN used as the clock, shiftClk held low as enable
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'hA0, 8'h00, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);
    hold(1'b0, 1'b0);
    hold(1'b0, 1'b1);
    chk("R5 swapped pins first shift", {15'd0, headOut}, 16'd0);
    hold(1'b0, 1'b0);
    hold(1'b0, 1'b1);
    chk("R5 swapped pins second shift", {15'd0, headOut}, 16'd1);

    // R8: release with enable high and clock low, versus both low
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 8'h00, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);
    hold(1'b0, 1'b1);
    chk("R8 release with enable high", {15'd0, headOut}, 16'd1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R8 release with both low keeps word", {15'd0, headOut}, 16'd1);
    hold(1'b1, 1'b0);
    chk("R8 first edge after low release shifts", {15'd0, headOut}, 16'd0);

    // R2: load priority while the clock toggles
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] pv;
      pv = W'($urandom);
      step(1'b0, 1'b0, k[0], 1'b0, pv, ~pv, 1'b1);
      chk("R2 load overrides clock", {15'd0, headOut}, {15'd0, pv[W-1]});
    end

    // Random phase against the model (R3 R4 R5 R9)
    for (int k = 0; k < 600; k++) begin
      logic ld;
      ld = ($urandom_range(0, 15) != 0);
      step(1'b0, ld, 1'($urandom), 1'($urandom_range(0, 3) == 0),
           W'($urandom), W'($urandom), 1'($urandom));
      chkModel("R3 R4 R5 R9 random");
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule